// File: doc/BRIEF.md
# Streaming Video Vertical Crop

This block sits in a pixel stream between an AXI4-Stream video input and an AXI4-Stream video output. It keeps the top half of every frame and discards the bottom half. Each beat carries a 24-bit pixel word and four 1-bit sideband fields: start-of-frame (user), end-of-line (last), id and destination. Two inputs set the frame geometry while the block runs: the line width in pixels and the frame height in lines. Both must stay constant for the length of a frame.

The block accepts every beat of every input frame, including the lines it throws away, so the upstream source always finishes its frame. Lines whose index is below half the frame height are copied to the output without change. The output frame therefore keeps its full width, has half the height rounded down, and keeps the original start-of-frame and end-of-line markers. A single output register holds at most one pixel. It sustains one pixel per clock when both sides are ready.

Top module: `vcrop_stream`

## Requirements
- R1: After a synchronous active-low reset, with both sizes nonzero, `m_tvalid` is 0 and `s_tready` is 1. The first beat accepted after reset is treated as line 0, pixel 0.
- R2: All hsize×vsize beats of each input frame are accepted from the input stream, including beats on lines that are discarded.
- R3: Only lines with index below floor(vsize/2) appear on the output, in input order. An odd vsize rounds down, so vsize=1 produces no output at all.
- R4: A forwarded beat leaves with its data, user, last, id and dest fields identical to the values it arrived with.
- R5: While a discarded line is being received, `s_tready` is 1 whatever the state of `m_tready`, and no output beat is produced from that line.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, the output beat is held unchanged on the next cycle. On a kept line, `s_tready` is 1 only when the output register is empty or is being emptied.
- R7: With the source always valid and the sink always ready, one beat is accepted on every clock, with no stall cycles.
- R8: When hsize or vsize is 0, `s_tready` stays 0 and no output beat is produced.
- R9: The pixel counter wraps after pixel hsize-1 and advances the line counter. The line counter wraps after line vsize-1, so the next beat starts a new frame at line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hsize | input | SIZE_W | Pixels per line |
| cfg_vsize | input | SIZE_W | Lines per input frame |
| s_tdata | input | DATA_W | Input pixel word |
| s_tuser | input | USER_W | Input start-of-frame marker |
| s_tlast | input | 1 | Input end-of-line marker |
| s_tid | input | ID_W | Input stream id |
| s_tdest | input | DEST_W | Input routing destination |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DATA_W | Output pixel word |
| m_tuser | output | USER_W | Output start-of-frame marker |
| m_tlast | output | 1 | Output end-of-line marker |
| m_tid | output | ID_W | Output stream id |
| m_tdest | output | DEST_W | Output routing destination |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat taken by the sink |

## Verification
The bench runs every frame geometry from 1×1 to 4×5 for two frames each. The pixel word encodes frame, line and column, and id and dest follow line and column parity, so a dropped, repeated, misordered or corrupted beat is caught, and so is a wrong wrap point. Odd heights and height 1 separate floor-division from other rounding. Source gaps and a stalling sink exercise the hold path. A run with the sink held low on a discarded line shows that input ready does not depend on the output side. A gap-free run with a sink that is always ready shows full throughput. Zero width and zero height show that the block does not consume input.

// File: rtl/vcrop_pkg.sv
package vcrop_pkg;

  // Widest size value the helper functions accept
  localparam int unsigned CNT_W_MAX = 16;

  typedef logic [CNT_W_MAX-1:0] size_t;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_KEEP = 2'd1,
    MODE_DROP = 2'd2
  } line_mode_e;

  // Number of lines forwarded per frame: height halved, rounded down
  function automatic size_t kept_lines(input size_t vsize);
    return vsize >> 1;
  endfunction

  // True when idx is the final index of a nonzero range of length size
  function automatic logic is_last_index(input size_t idx, input size_t size);
    return (size != '0) && (idx >= size - size_t'(1));
  endfunction

  // Line handling for the current line index
  function automatic line_mode_e pick_mode(input size_t row, input size_t hsize,
                                           input size_t vsize);
    if (hsize == '0 || vsize == '0) return MODE_IDLE;
    if (row < kept_lines(vsize))    return MODE_KEEP;
    return MODE_DROP;
  endfunction

endpackage

// File: rtl/vcrop_raster.sv
module vcrop_raster
  import vcrop_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] hsize,
  input  logic [SIZE_W-1:0] vsize,
  input  logic              step,
  output logic [SIZE_W-1:0] col,
  output logic [SIZE_W-1:0] row,
  output logic              line_end,
  output logic              frame_end
);

  logic [SIZE_W-1:0] col_q, row_q;

  assign line_end  = is_last_index(size_t'(col_q), size_t'(hsize));
  assign frame_end = line_end && is_last_index(size_t'(row_q), size_t'(vsize));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (line_end) begin
        col_q <= '0;
        row_q <= frame_end ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign col = col_q;
  assign row = row_q;

  // R9
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && line_end) |=> (col == '0));

  // R9
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && frame_end) |=> (row == '0 && col == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(col) && $stable(row)));

endmodule

// File: rtl/vcrop_gate.sv
module vcrop_gate
  import vcrop_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] hsize,
  input  logic [SIZE_W-1:0] vsize,
  input  logic [SIZE_W-1:0] row,
  input  logic              in_valid,
  input  logic              out_full,
  input  logic              out_ready,
  output line_mode_e        mode,
  output logic              in_ready,
  output logic              accept,
  output logic              load
);

  assign mode = pick_mode(size_t'(row), size_t'(hsize), size_t'(vsize));

  always_comb begin
    unique case (mode)
      MODE_KEEP: in_ready = !out_full || out_ready;
      MODE_DROP: in_ready = 1'b1;
      default:   in_ready = 1'b0;
    endcase
  end

  assign accept = in_valid && in_ready;
  assign load   = accept && (mode == MODE_KEEP);

  // R8
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsize == '0 || vsize == '0) |-> (!in_ready && !load));

  // R5
  drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsize != '0 && vsize != '0 && size_t'(row) >= kept_lines(size_t'(vsize)))
      |-> (in_ready && !load));

endmodule

// File: rtl/vcrop_beat_reg.sv
module vcrop_beat_reg #(
  parameter int DATA_W = 24,
  parameter int USER_W = 1,
  parameter int ID_W   = 1,
  parameter int DEST_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic [USER_W-1:0] d_user,
  input  logic              d_last,
  input  logic [ID_W-1:0]   d_id,
  input  logic [DEST_W-1:0] d_dest,
  input  logic              q_ready,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic [USER_W-1:0] q_user,
  output logic              q_last,
  output logic [ID_W-1:0]   q_id,
  output logic [DEST_W-1:0] q_dest
);

  localparam int BEAT_W = DATA_W + USER_W + 1 + ID_W + DEST_W;

  logic              valid_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= 1'b0;
    else if (load)    valid_q <= 1'b1;
    else if (q_ready) valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) beat_q <= {d_data, d_user, d_last, d_id, d_dest};
  end

  assign q_valid = valid_q;
  assign {q_data, q_user, q_last, q_id, q_dest} = beat_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(beat_q)));

  // R6
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!q_valid || q_ready));

endmodule

// File: rtl/vcrop_stream.sv
module vcrop_stream
  import vcrop_pkg::*;
#(
  parameter int SIZE_W = 12,
  parameter int DATA_W = 24,
  parameter int USER_W = 1,
  parameter int ID_W   = 1,
  parameter int DEST_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] cfg_hsize,
  input  logic [SIZE_W-1:0] cfg_vsize,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [USER_W-1:0] s_tuser,
  input  logic              s_tlast,
  input  logic [ID_W-1:0]   s_tid,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast,
  output logic [ID_W-1:0]   m_tid,
  output logic [DEST_W-1:0] m_tdest,
  output logic              m_tvalid,
  input  logic              m_tready
);

  // Named internal events
  logic [SIZE_W-1:0] pix_col, pix_row;
  logic              at_line_end, at_frame_end;
  logic              in_fire, out_load;
  line_mode_e        line_mode;

  vcrop_raster #(.SIZE_W(SIZE_W)) u_raster (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsize     (cfg_hsize),
    .vsize     (cfg_vsize),
    .step      (in_fire),
    .col       (pix_col),
    .row       (pix_row),
    .line_end  (at_line_end),
    .frame_end (at_frame_end)
  );

  vcrop_gate #(.SIZE_W(SIZE_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsize     (cfg_hsize),
    .vsize     (cfg_vsize),
    .row       (pix_row),
    .in_valid  (s_tvalid),
    .out_full  (m_tvalid),
    .out_ready (m_tready),
    .mode      (line_mode),
    .in_ready  (s_tready),
    .accept    (in_fire),
    .load      (out_load)
  );

  vcrop_beat_reg #(
    .DATA_W (DATA_W),
    .USER_W (USER_W),
    .ID_W   (ID_W),
    .DEST_W (DEST_W)
  ) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (out_load),
    .d_data  (s_tdata),
    .d_user  (s_tuser),
    .d_last  (s_tlast),
    .d_id    (s_tid),
    .d_dest  (s_tdest),
    .q_ready (m_tready),
    .q_valid (m_tvalid),
    .q_data  (m_tdata),
    .q_user  (m_tuser),
    .q_last  (m_tlast),
    .q_id    (m_tid),
    .q_dest  (m_tdest)
  );

  // R3
  drop_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && line_mode == MODE_DROP) |=> !$rose(m_tvalid));

  // R4
  pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |=> (m_tvalid && m_tdata == $past(s_tdata) && m_tlast == $past(s_tlast)));

endmodule

// File: tb/vcrop_stream_tb.sv
module vcrop_stream_tb;

  localparam int SIZE_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SIZE_W-1:0] cfg_hsize = '0, cfg_vsize = '0;
  logic [23:0]       s_tdata = '0;
  logic              s_tuser = 1'b0, s_tlast = 1'b0, s_tid = 1'b0, s_tdest = 1'b0;
  logic              s_tvalid = 1'b0;
  logic              s_tready;
  logic [23:0]       m_tdata;
  logic              m_tuser, m_tlast, m_tid, m_tdest, m_tvalid;
  logic              m_tready = 1'b0;

  vcrop_stream #(.SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_hsize(cfg_hsize), .cfg_vsize(cfg_vsize),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tid(s_tid),
    .s_tdest(s_tdest), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast), .m_tid(m_tid),
    .m_tdest(m_tdest), .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0;
  int cur_h = 1, cur_v = 1;
  int exp_k = 0, acc_cnt = 0, stall_cnt = 0, pat = 0;
  bit sink_full = 1'b0, sink_low = 1'b0, sink_en = 1'b0;
  bit prev_stall = 1'b0;
  logic [23:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pix_word(input int fr, input int r, input int c);
    return {8'(fr), 8'(r), 8'(c)};
  endfunction

  // Sink: drives ready at negedge, checks each handshake ahead of its edge
  always begin
    @(negedge clk);
    m_tready = sink_low ? 1'b0 : (sink_full ? 1'b1 : ((pat % 4) != 3));
    pat++;
    #2;
    if (sink_en) begin
      if (prev_stall) begin
        // R6: stalled beat held unchanged
        chk(m_tvalid && m_tdata == prev_data, "R6 hold", int'(m_tdata), int'(prev_data));
      end
      prev_stall = m_tvalid && !m_tready;
      prev_data  = m_tdata;
      if (m_tvalid && m_tready) begin
        int per, fr, r, c;
        per = cur_h * (cur_v / 2);
        if (per == 0) begin
          chk(1'b0, "R3 unexpected beat", int'(m_tdata), -1);
        end else begin
          fr = exp_k / per;
          r  = (exp_k % per) / cur_h;
          c  = exp_k % cur_h;
          // R3 order and R4 exact copy, R9 second frame restarts at line 0
          chk(m_tdata == pix_word(fr, r, c), "R3/R4 data", int'(m_tdata), int'(pix_word(fr, r, c)));
          chk(m_tuser == (r == 0 && c == 0), "R4 user", int'(m_tuser), int'(r == 0 && c == 0));
          chk(m_tlast == (c == cur_h - 1), "R4 last", int'(m_tlast), int'(c == cur_h - 1));
          chk(m_tid == r[0] && m_tdest == c[0], "R4 id/dest", int'({m_tid, m_tdest}), int'({r[0], c[0]}));
        end
        exp_k++;
      end
    end
  end

  // Call at a negedge; returns at the negedge after the handshake
  task automatic push(input int fr, input int r, input int c, input int h);
    s_tvalid = 1'b1;
    s_tdata  = pix_word(fr, r, c);
    s_tuser  = (r == 0 && c == 0);
    s_tlast  = (c == h - 1);
    s_tid    = r[0];
    s_tdest  = c[0];
    #1;
    while (!s_tready) begin
      stall_cnt++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    acc_cnt++;
  endtask

  task automatic send_frame(input int fr, input int h, input int v, input bit gaps);
    for (int r = 0; r < v; r++)
      for (int c = 0; c < h; c++) begin
        push(fr, r, c, h);
        if (gaps && ((r + c + fr) % 3 == 0)) @(negedge clk);
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_hsize = 12'd2;
    cfg_vsize = 12'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(m_tvalid == 1'b0, "R1 m_tvalid", int'(m_tvalid), 0);
    chk(s_tready == 1'b1, "R1 s_tready", int'(s_tready), 1);
    sink_en = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R9: geometry sweep, two frames each, gaps and stalling sink
    for (int h = 1; h <= 4; h++)
      for (int v = 1; v <= 5; v++) begin
        cur_h = h; cur_v = v; exp_k = 0; acc_cnt = 0;
        cfg_hsize = SIZE_W'(h);
        cfg_vsize = SIZE_W'(v);
        send_frame(0, h, v, 1'b1);
        send_frame(1, h, v, 1'b1);
        repeat (8) @(negedge clk);
        chk(acc_cnt == 2 * h * v, "R2 accepted beats", acc_cnt, 2 * h * v);
        chk(exp_k == 2 * h * (v / 2), "R3 output beats", exp_k, 2 * h * (v / 2));
      end

    // R7: full throughput
    cur_h = 4; cur_v = 4; exp_k = 0; stall_cnt = 0; sink_full = 1'b1;
    cfg_hsize = 12'd4; cfg_vsize = 12'd4;
    send_frame(0, 4, 4, 1'b0);
    chk(stall_cnt == 0, "R7 stall cycles", stall_cnt, 0);
    repeat (4) @(negedge clk);
    chk(exp_k == 8, "R7 output beats", exp_k, 8);

    // R5: discarded line accepted while sink refuses
    cur_h = 3; cur_v = 2; exp_k = 0;
    cfg_hsize = 12'd3; cfg_vsize = 12'd2;
    for (int c = 0; c < 3; c++) push(0, 0, c, 3);
    repeat (3) @(negedge clk);
    sink_low = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      s_tvalid = 1'b1;
      s_tdata  = pix_word(0, 1, c);
      s_tuser  = 1'b0;
      s_tlast  = (c == 2);
      s_tid    = 1'b1;
      s_tdest  = c[0];
      #1;
      chk(s_tready == 1'b1, "R5 s_tready on dropped line", int'(s_tready), 1);
      chk(m_tvalid == 1'b0, "R5 m_tvalid on dropped line", int'(m_tvalid), 0);
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    #1;
    chk(m_tvalid == 1'b0, "R5 no output after dropped line", int'(m_tvalid), 0);
    sink_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_k == 3, "R3 kept beats", exp_k, 3);

    // R8: zero width, then zero height
    for (int z = 0; z < 2; z++) begin
      cfg_hsize = (z == 0) ? 12'd0 : 12'd3;
      cfg_vsize = (z == 0) ? 12'd2 : 12'd0;
      s_tvalid = 1'b1;
      s_tdata  = 24'hABCDEF;
      repeat (4) begin
        #1;
        chk(s_tready == 1'b0, "R8 s_tready", int'(s_tready), 0);
        chk(m_tvalid == 1'b0, "R8 m_tvalid", int'(m_tvalid), 0);
        @(negedge clk);
      end
      s_tvalid = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule